// File: doc/BRIEF.md
# Reference Validity and Fail Interrupt

This block judges, for every reference clock input of a timing device, whether that input may be used. It takes the alarm results of the per-input quality monitors and returns one validity flag per input. A set of enable bits decides how strict the judgement is. Two of the checks can be switched off: the edge-noise check for low-rate inputs, and the missed-cycle check on the input that is currently selected.

It also records events. A sticky change bit per input records any change of that input's validity. A separate sticky flag records a failure of the selected reference, meaning that input went from valid to invalid. Both kinds of sticky bit can raise one shared interrupt line through their own enable bits. The failure flag can also drive a dedicated indicator pin, which stays high until software clears the flag. Sticky bits are cleared with one-cycle clear strobes: writing one to a bit clears it.

There is no data stream here. All pins are plain control and status levels or strobes, so there is no valid/ready handshake and no back-pressure. Every registered output follows its inputs with one cycle of latency.

Top module: `ref_validity_irq`

## Requirements
- R1: An input is judged invalid on the cycle after any of its no-activity, frequency-hard or phase-lock alarms is high. It is judged valid on the cycle after all three are low and the enabled optional terms (R2, R3) pass.
- R2: When `noise_chk_en` is 1, a high `noise_viol[i]` makes input i invalid. When `noise_chk_en` is 0, `noise_viol` has no effect on validity.
- R3: When `fast_sw_en` is 1, the input whose index equals `sel_idx` is invalid while `miss_cnt` is 2 or more. Inputs that are not selected are not affected. When `fast_sw_en` is 0, `miss_cnt` is ignored.
- R4: Any change of `ref_valid[i]`, in either direction, sets `chg_sticky[i]` on the same edge. The first edge after reset only loads validity and records no change.
- R5: `mfail_sticky` is set only when the input indexed by `sel_idx` goes from valid to invalid. Invalid-to-valid transitions and failures of other inputs leave it unchanged.
- R6: A high bit of `chg_clr` clears the matching change bit, and `mfail_clr` clears `mfail_sticky`. Otherwise sticky bits hold. A new event in the same cycle as a clear wins, and the bit stays set.
- R7: `irq` is high exactly when some `chg_sticky[i]` is set with `chg_irq_en[i]` = 1, or `mfail_sticky` is set with `mfail_irq_en` = 1.
- R8: `fail_pin` is high when `mfail_to_pin_en`, `mfail_irq_en` and `mfail_sticky` are all 1. Once high it stays high until `mfail_sticky` is cleared or one of the two enables drops.
- R9: While `rst_n` is low, `ref_valid`, `chg_sticky`, `mfail_sticky`, `irq` and `fail_pin` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| no_act_alarm | input | N_REF | Per-input no-activity alarm |
| freq_hard_alarm | input | N_REF | Per-input frequency hard alarm |
| ph_lock_alarm | input | N_REF | Per-input phase-lock alarm |
| noise_viol | input | N_REF | Per-input edge-noise window violation |
| miss_cnt | input | MISS_W | Consecutive missed cycles of the selected input |
| sel_idx | input | SEL_W | Index of the currently selected input |
| noise_chk_en | input | 1 | Include the noise term in validity |
| fast_sw_en | input | 1 | Include the missed-cycle term for the selected input |
| chg_irq_en | input | N_REF | Per-input change interrupt enable |
| mfail_irq_en | input | 1 | Main-failure interrupt enable |
| mfail_to_pin_en | input | 1 | Route the main-failure interrupt to `fail_pin` |
| chg_clr | input | N_REF | Write-one-to-clear strobes for change bits |
| mfail_clr | input | 1 | Write-one-to-clear strobe for `mfail_sticky` |
| ref_valid | output | N_REF | Registered validity per input |
| chg_sticky | output | N_REF | Sticky validity-change bits |
| mfail_sticky | output | 1 | Sticky main-reference-failed flag |
| irq | output | 1 | Combined interrupt line |
| fail_pin | output | 1 | Main-failure indicator pin |

## Verification
The checker watches several rules on every cycle:
- an alarm always produces invalidity one cycle later;
- every observed validity change is matched by a set change bit;
- sticky bits never drop without a clear;
- a rising failure flag always coincides with the selected input falling from valid to invalid;
- the indicator pin never stands high without the interrupt and its own enable.

The directed scenarios are needed for the rest: whether the optional noise and missed-cycle terms are really ignored when disabled, whether non-selected inputs escape the missed-cycle term, how a set and a clear in the same cycle resolve, and how each enable gates the interrupt.

// File: rtl/ref_validity_pkg.sv
package ref_validity_pkg;

  // Alarm bundle of one reference input, as seen by the qualifier.
  typedef struct packed {
    logic no_act;
    logic freq_hard;
    logic ph_lock;
    logic noise;
  } ref_alarm_t;

  // Index width for a count of inputs, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ref_qual_combine.sv
module ref_qual_combine
  import ref_validity_pkg::*;
#(
  parameter int N_REF      = 4,
  parameter int MISS_W     = 3,
  parameter int MISS_LIMIT = 2,
  parameter int SEL_W      = 2
) (
  input  ref_alarm_t [N_REF-1:0] alarms,
  input  logic [MISS_W-1:0]      miss_cnt,
  input  logic [SEL_W-1:0]       sel_idx,
  input  logic                   noise_chk_en,
  input  logic                   fast_sw_en,
  output logic [N_REF-1:0]       valid_now
);

  localparam logic [MISS_W-1:0] MISS_THR = MISS_W'(MISS_LIMIT);

  // Missed-cycle term, shared: it only ever applies to the selected input.
  logic miss_bad;
  assign miss_bad = fast_sw_en && (miss_cnt >= MISS_THR);

  for (genvar i = 0; i < N_REF; i++) begin : g_in
    logic hard_bad;
    logic noise_bad;
    logic is_sel;
    assign hard_bad  = alarms[i].no_act | alarms[i].freq_hard | alarms[i].ph_lock;
    assign noise_bad = noise_chk_en & alarms[i].noise;
    assign is_sel    = (sel_idx == SEL_W'(i));
    assign valid_now[i] = ~(hard_bad | noise_bad | (is_sel & miss_bad));
  end

endmodule

// File: rtl/ref_change_track.sv
module ref_change_track #(
  parameter int N_REF = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REF-1:0] valid_now,
  input  logic [SEL_W-1:0] sel_idx,
  output logic [N_REF-1:0] valid_q,
  output logic [N_REF-1:0] chg_evt,
  output logic             mfail_evt
);

  // Suppresses events on the first edge after reset, when valid_q is
  // loaded from its reset value rather than from a real history.
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      valid_q  <= valid_now;
      primed_q <= 1'b1;
    end
  end

  assign chg_evt = primed_q ? (valid_now ^ valid_q) : '0;

  // Main-failure event: the selected input falls from valid to invalid.
  logic [N_REF-1:0] fall_vec;
  logic [N_REF-1:0] sel_vec;
  assign fall_vec = valid_q & ~valid_now;

  for (genvar i = 0; i < N_REF; i++) begin : g_sel
    assign sel_vec[i] = (sel_idx == SEL_W'(i));
  end

  assign mfail_evt = primed_q & |(fall_vec & sel_vec);

endmodule

// File: rtl/sticky_w1c.sv
module sticky_w1c #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  // Set has priority over a clear in the same cycle.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[b] <= 1'b0;
      else if (set_evt[b])
        q[b] <= 1'b1;
      else if (clr[b])
        q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N_REF = 4
) (
  input  logic [N_REF-1:0] chg_q,
  input  logic [N_REF-1:0] chg_en,
  input  logic             mfail_q,
  input  logic             mfail_en,
  input  logic             pin_en,
  output logic             irq,
  output logic             fail_pin
);

  logic mfail_irq;
  assign mfail_irq = mfail_q & mfail_en;
  assign irq       = (|(chg_q & chg_en)) | mfail_irq;
  assign fail_pin  = mfail_irq & pin_en;

endmodule

// File: rtl/ref_validity_irq.sv
module ref_validity_irq
  import ref_validity_pkg::*;
#(
  parameter int N_REF      = 4,
  parameter int MISS_W     = 3,
  parameter int MISS_LIMIT = 2,
  localparam int SEL_W     = idx_width(N_REF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REF-1:0]  no_act_alarm,
  input  logic [N_REF-1:0]  freq_hard_alarm,
  input  logic [N_REF-1:0]  ph_lock_alarm,
  input  logic [N_REF-1:0]  noise_viol,
  input  logic [MISS_W-1:0] miss_cnt,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic              noise_chk_en,
  input  logic              fast_sw_en,
  input  logic [N_REF-1:0]  chg_irq_en,
  input  logic              mfail_irq_en,
  input  logic              mfail_to_pin_en,
  input  logic [N_REF-1:0]  chg_clr,
  input  logic              mfail_clr,
  output logic [N_REF-1:0]  ref_valid,
  output logic [N_REF-1:0]  chg_sticky,
  output logic              mfail_sticky,
  output logic              irq,
  output logic              fail_pin
);

  ref_alarm_t [N_REF-1:0] alarms;
  logic [N_REF-1:0]       valid_now;
  logic [N_REF-1:0]       chg_evt;
  logic                   mfail_evt;

  for (genvar i = 0; i < N_REF; i++) begin : g_pack
    assign alarms[i].no_act    = no_act_alarm[i];
    assign alarms[i].freq_hard = freq_hard_alarm[i];
    assign alarms[i].ph_lock   = ph_lock_alarm[i];
    assign alarms[i].noise     = noise_viol[i];
  end

  ref_qual_combine #(
    .N_REF(N_REF), .MISS_W(MISS_W), .MISS_LIMIT(MISS_LIMIT), .SEL_W(SEL_W)
  ) u_qual (
    .alarms      (alarms),
    .miss_cnt    (miss_cnt),
    .sel_idx     (sel_idx),
    .noise_chk_en(noise_chk_en),
    .fast_sw_en  (fast_sw_en),
    .valid_now   (valid_now)
  );

  ref_change_track #(.N_REF(N_REF), .SEL_W(SEL_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_now(valid_now),
    .sel_idx  (sel_idx),
    .valid_q  (ref_valid),
    .chg_evt  (chg_evt),
    .mfail_evt(mfail_evt)
  );

  sticky_w1c #(.W(N_REF)) u_chg_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(chg_evt),
    .clr    (chg_clr),
    .q      (chg_sticky)
  );

  sticky_w1c #(.W(1)) u_mfail_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(mfail_evt),
    .clr    (mfail_clr),
    .q      (mfail_sticky)
  );

  irq_merge #(.N_REF(N_REF)) u_irq (
    .chg_q   (chg_sticky),
    .chg_en  (chg_irq_en),
    .mfail_q (mfail_sticky),
    .mfail_en(mfail_irq_en),
    .pin_en  (mfail_to_pin_en),
    .irq     (irq),
    .fail_pin(fail_pin)
  );

endmodule

// File: rtl/ref_validity_irq_chk.sv
module ref_validity_irq_chk #(
  parameter int N_REF = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REF-1:0] no_act_alarm,
  input logic [N_REF-1:0] freq_hard_alarm,
  input logic [N_REF-1:0] ph_lock_alarm,
  input logic [SEL_W-1:0] sel_idx,
  input logic [N_REF-1:0] chg_clr,
  input logic             mfail_clr,
  input logic             mfail_irq_en,
  input logic             mfail_to_pin_en,
  input logic [N_REF-1:0] ref_valid,
  input logic [N_REF-1:0] chg_sticky,
  input logic             mfail_sticky,
  input logic             irq,
  input logic             fail_pin
);

  // Edges seen since reset, saturating at 2.
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_a
    assert_alarm_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (no_act_alarm[i] | freq_hard_alarm[i] | ph_lock_alarm[i]) |=> !ref_valid[i]);

    assert_change_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2 && ref_valid[i] != $past(ref_valid[i])) |-> chg_sticky[i]);

    assert_chg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_sticky[i] && !chg_clr[i]) |=> chg_sticky[i]);
  end

  assert_mfail_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfail_sticky) |-> ($past(ref_valid[sel_idx]) && !ref_valid[$past(sel_idx)]));

  assert_mfail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mfail_sticky && !mfail_clr) |=> mfail_sticky);

  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_sticky == '0 && !mfail_sticky) |-> !irq);

  assert_pin_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pin |-> (irq && mfail_sticky && mfail_to_pin_en));

  assert_pin_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pin && !mfail_clr && mfail_irq_en && mfail_to_pin_en)
      |=> (fail_pin || !mfail_irq_en || !mfail_to_pin_en));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R9: assert (ref_valid == '0 && chg_sticky == '0 &&
                                     !mfail_sticky && !irq && !fail_pin);
    end
  end

endmodule

bind ref_validity_irq ref_validity_irq_chk #(.N_REF(N_REF), .SEL_W(SEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .no_act_alarm   (no_act_alarm),
  .freq_hard_alarm(freq_hard_alarm),
  .ph_lock_alarm  (ph_lock_alarm),
  .sel_idx        (sel_idx),
  .chg_clr        (chg_clr),
  .mfail_clr      (mfail_clr),
  .mfail_irq_en   (mfail_irq_en),
  .mfail_to_pin_en(mfail_to_pin_en),
  .ref_valid      (ref_valid),
  .chg_sticky     (chg_sticky),
  .mfail_sticky   (mfail_sticky),
  .irq            (irq),
  .fail_pin       (fail_pin)
);

// File: tb/tb_ref_validity_irq.sv
module tb_ref_validity_irq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int MW         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  no_act = '0, freq_hard = '0, ph_lock = '0, noise_v = '0;
  logic [MW-1:0] miss = '0;
  logic [1:0]    sel = '0;
  logic          noise_en = 1'b0, fast_en = 1'b0;
  logic [N-1:0]  chg_en = '0;
  logic          mf_en = 1'b0, pin_en = 1'b0;
  logic [N-1:0]  chg_clr = '0;
  logic          mf_clr = 1'b0;
  logic [N-1:0]  ref_valid, chg_sticky;
  logic          mfail_sticky, irq, fail_pin;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_validity_irq #(.N_REF(N), .MISS_W(MW), .MISS_LIMIT(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .no_act_alarm(no_act), .freq_hard_alarm(freq_hard), .ph_lock_alarm(ph_lock),
    .noise_viol(noise_v), .miss_cnt(miss), .sel_idx(sel),
    .noise_chk_en(noise_en), .fast_sw_en(fast_en),
    .chg_irq_en(chg_en), .mfail_irq_en(mf_en), .mfail_to_pin_en(pin_en),
    .chg_clr(chg_clr), .mfail_clr(mf_clr),
    .ref_valid(ref_valid), .chg_sticky(chg_sticky), .mfail_sticky(mfail_sticky),
    .irq(irq), .fail_pin(fail_pin)
  );

  // Inputs change just after a falling edge; outputs are read at the next
  // falling edge, one rising edge later.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic clear_all();
    chg_clr = '1; mf_clr = 1'b1;
    tick();
    chg_clr = '0; mf_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R9", "valid", 32'(ref_valid), 32'h0);
    chk("R9", "chg", 32'(chg_sticky), 32'h0);
    chk("R9", "mfail/irq/pin", {29'd0, mfail_sticky, irq, fail_pin}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1", "valid after reset", 32'(ref_valid), 32'hF);
    chk("R4", "no change on priming edge", 32'(chg_sticky), 32'h0);
  endtask

  task automatic t_alarm_terms();
    no_act[1] = 1'b1; tick();
    chk("R1", "no-activity", 32'(ref_valid), 32'hD);
    chk("R4", "fall flagged", 32'(chg_sticky), 32'h2);
    chk("R5", "non-selected fall", 32'(mfail_sticky), 32'h0);
    no_act[1] = 1'b0; freq_hard[2] = 1'b1; tick();
    chk("R1", "freq hard", 32'(ref_valid), 32'hB);
    chk("R4", "rise and fall flagged", 32'(chg_sticky), 32'h6);
    freq_hard[2] = 1'b0; ph_lock[3] = 1'b1; tick();
    chk("R1", "phase lock", 32'(ref_valid), 32'h7);
    chk("R4", "accumulate", 32'(chg_sticky), 32'hE);
    ph_lock[3] = 1'b0; tick();
    chk("R1", "all clean", 32'(ref_valid), 32'hF);
    clear_all();
    chk("R6", "cleared", 32'(chg_sticky), 32'h0);
  endtask

  task automatic t_noise();
    noise_v[2] = 1'b1; noise_en = 1'b0; tick();
    chk("R2", "noise ignored valid", 32'(ref_valid), 32'hF);
    chk("R2", "noise ignored chg", 32'(chg_sticky), 32'h0);
    noise_en = 1'b1; tick();
    chk("R2", "noise enabled", 32'(ref_valid), 32'hB);
    chk("R4", "noise fall", 32'(chg_sticky), 32'h4);
    noise_en = 1'b0; tick();
    chk("R2", "noise disabled again", 32'(ref_valid), 32'hF);
    noise_v = '0;
    clear_all();
  endtask

  task automatic t_fast();
    sel = 2'd1; miss = 3'd2; fast_en = 1'b0; tick();
    chk("R3", "miss ignored", 32'(ref_valid), 32'hF);
    fast_en = 1'b1; tick();
    chk("R3", "selected invalid", 32'(ref_valid), 32'hD);
    chk("R5", "selected fail sets flag", 32'(mfail_sticky), 32'h1);
    miss = 3'd1; tick();
    chk("R3", "one miss tolerated", 32'(ref_valid), 32'hF);
    sel = 2'd2; miss = 3'd3; tick();
    chk("R3", "term follows selection", 32'(ref_valid), 32'hB);
    chk("R4", "both flagged", 32'(chg_sticky), 32'h6);
    fast_en = 1'b0; miss = '0; sel = 2'd0; tick();
    chk("R3", "released", 32'(ref_valid), 32'hF);
    clear_all();
    chk("R6", "all cleared", {27'd0, mfail_sticky, chg_sticky}, 32'h0);
  endtask

  task automatic t_mfail();
    sel = 2'd0;
    no_act[0] = 1'b1; tick();
    chk("R5", "selected fails", 32'(mfail_sticky), 32'h1);
    chk("R4", "chg of selected", 32'(chg_sticky), 32'h1);
    mf_clr = 1'b1; tick(); mf_clr = 1'b0;
    chk("R6", "mfail cleared while still invalid", 32'(mfail_sticky), 32'h0);
    no_act[0] = 1'b0; tick();
    chk("R5", "recovery does not set", 32'(mfail_sticky), 32'h0);
    chk("R4", "recovery flagged", 32'(chg_sticky), 32'h1);
    clear_all();
  endtask

  task automatic t_set_beats_clear();
    no_act[1] = 1'b1; chg_clr = 4'h2; tick(); chg_clr = '0;
    chk("R6", "set wins over clear", 32'(chg_sticky), 32'h2);
    chg_clr = 4'h2; tick(); chg_clr = '0;
    chk("R6", "plain clear", 32'(chg_sticky), 32'h0);
    sel = 2'd1; no_act[1] = 1'b0; tick();
    no_act[1] = 1'b1; mf_clr = 1'b1; tick(); mf_clr = 1'b0;
    chk("R6", "mfail set wins over clear", 32'(mfail_sticky), 32'h1);
    no_act[1] = 1'b0; tick();
    sel = 2'd0;
    clear_all();
  endtask

  task automatic t_irq();
    chg_en = '0; no_act[3] = 1'b1; tick();
    chk("R7", "masked change", 32'(irq), 32'h0);
    chg_en = 4'h4; tick();
    chk("R7", "other enable", 32'(irq), 32'h0);
    chg_en = 4'h8; tick();
    chk("R7", "matching enable", 32'(irq), 32'h1);
    chg_clr = 4'h8; tick(); chg_clr = '0;
    chk("R7", "cleared source", 32'(irq), 32'h0);
    no_act[3] = 1'b0; tick();
    chk("R7", "recovery raises irq", 32'(irq), 32'h1);
    chg_en = '0;
    clear_all();
  endtask

  task automatic t_fail_pin();
    sel = 2'd0; mf_en = 1'b0; pin_en = 1'b1;
    no_act[0] = 1'b1; tick();
    chk("R7", "mfail masked irq", 32'(irq), 32'h0);
    chk("R8", "pin needs irq enable", 32'(fail_pin), 32'h0);
    mf_en = 1'b1; tick();
    chk("R8", "pin high", {30'd0, irq, fail_pin}, 32'h3);
    pin_en = 1'b0; tick();
    chk("R8", "routing off", {30'd0, irq, fail_pin}, 32'h2);
    pin_en = 1'b1; repeat (3) tick();
    chk("R8", "pin held", 32'(fail_pin), 32'h1);
    mf_clr = 1'b1; tick(); mf_clr = 1'b0;
    chk("R8", "pin released by clear", {30'd0, irq, fail_pin}, 32'h0);
    no_act[0] = 1'b0; tick();
    clear_all();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_alarm_terms();
    t_noise();
    t_fast();
    t_mfail();
    t_set_beats_clear();
    t_irq();
    t_fail_pin();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule